// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. Software programs a reload value, a prescaler choice and the kind of timeout signalling it wants. It then has to write a magic restart word before the counter runs out. If the counter reaches zero while the watchdog runs, the block either emits a reset pulse of a chosen length or raises a level interrupt, or both. A sticky status flag records the expiry.

Every configuration word has to carry a key field that matches its register. A stray or corrupted write therefore cannot reconfigure or silence the timer. The counter is the 12-bit reload field placed above a run of zero bits (`CNT_LSB`, default 12). It is decremented once per prescaled tick.

Top module: `key_wdt`

## Requirements
- R1: A write to word 0 (settings) changes the register only when bits 23:12 of the data equal 0xABC. Otherwise the register keeps its value. Field positions are: bit 0 run, bit 1 reset-output enable, bit 2 interrupt enable, bits 5:4 pulse-length code.
- R2: A write to word 1 (timing) changes the register only when bits 25:14 equal 0x248, which is the pattern 0x0092_0000. Field positions are: bits 13:2 reload value, bits 1:0 prescaler select.
- R3: Reads return the stored fields at the positions given in R1 and R2, with key bits read as zero. Word 3 bit 0 reads the expiry flag. Word 2 reads zero.
- R4: A write of exactly 0x0000_1999 to word 2 reloads the counter and restarts the prescaler. Any other value written there has no effect on the timing.
- R5: After a reload, expiry is flagged reload × 2^CNT_LSB × divisor + 1 cycles later. The divisor is 8, 64, 512 or 4096 for select values 0, 1, 2 and 3.
- R6: On expiry with the reset output enabled, `wdt_rst_o` is high for 2, 4, 8 or 16 cycles for pulse-length codes 0 to 3. It never pulses when the reset output is disabled.
- R7: On expiry with the interrupt enabled, `wdt_irq_o` rises and stays high until a restart or a disable.
- R8: The expiry flag is sticky. A valid restart write or clearing the run bit clears it.
- R9: While the run bit is clear, the counter does not advance and both outputs are low. Setting the run bit from 0 to 1 loads the counter from the reload field.
- R10: After reset the watchdog is stopped, both outputs are low, word 0 reads 0, word 1 reads 0x3FFF and word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; word index in bits 3:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| wdt_rst_o | output | 1 | Timeout reset pulse |
| wdt_irq_o | output | 1 | Timeout interrupt level |

## Verification
On every cycle, the assertions check the following. A write with a wrong key leaves the settings or timing register unchanged. Every prescaler tick wraps its divider and takes exactly one step off a running counter. The expiry flag can only rise from a zero count. A stopped watchdog clears its flag and pulse state, and the pulse counter stays within its largest length. The exact expiry cycle for each prescaler choice and each pulse length can only be shown by the bench scenarios. The same holds for the rejection of a near-miss restart word, for clearing by restart versus by disable, and for reloading when the run bit is set.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int RELOAD_W = 12;
  localparam int SEL_W    = 2;
  localparam int KEY_W    = 12;
  localparam int PULSE_W  = 5;

  localparam logic [1:0] IDX_MODE = 2'd0;
  localparam logic [1:0] IDX_TIME = 2'd1;
  localparam logic [1:0] IDX_KICK = 2'd2;
  localparam logic [1:0] IDX_STAT = 2'd3;

  localparam logic [KEY_W-1:0] MODE_KEY  = 12'hABC;
  localparam logic [KEY_W-1:0] TIME_KEY  = 12'h248;
  localparam logic [31:0]      KICK_WORD = 32'h0000_1999;

  typedef struct packed {
    logic [1:0] pulse_len;
    logic       irq_en;
    logic       rst_en;
    logic       run;
  } mode_t;

  typedef struct packed {
    logic [RELOAD_W-1:0] reload;
    logic [SEL_W-1:0]    div_sel;
  } time_t;

  localparam time_t TIME_RST = '{reload: {RELOAD_W{1'b1}}, div_sel: 2'd3};
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              status_i,
  output mode_t             mode_o,
  output time_t             time_o,
  output logic              load_o,
  output logic [31:0]       bus_rdata
);
  logic       hit;
  logic [1:0] idx;
  logic       wr, rd;
  logic       mode_we, time_we, kick;
  mode_t      mode_q, mode_d;
  time_t      time_q, time_d;

  assign idx = bus_addr[3:2];
  assign hit = ((bus_addr >> 4) == '0) && (bus_addr[1:0] == 2'b00);
  assign wr  = bus_valid && bus_write && hit;
  assign rd  = bus_valid && !bus_write && hit;

  always_comb begin
    mode_we = 1'b0;
    time_we = 1'b0;
    kick    = 1'b0;
    mode_d  = mode_q;
    time_d  = time_q;
    if (wr) begin
      case (idx)
        IDX_MODE: if (bus_wdata[23:12] == MODE_KEY) begin
          mode_we = 1'b1;
          mode_d  = '{pulse_len: bus_wdata[5:4], irq_en: bus_wdata[2],
                      rst_en: bus_wdata[1], run: bus_wdata[0]};
        end
        IDX_TIME: if (bus_wdata[25:14] == TIME_KEY) begin
          time_we = 1'b1;
          time_d  = '{reload: bus_wdata[13:2], div_sel: bus_wdata[1:0]};
        end
        IDX_KICK: kick = (bus_wdata == KICK_WORD);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      time_q <= TIME_RST;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (time_we) time_q <= time_d;
    end
  end

  // counter reload on a restart word or on a stopped-to-running transition
  assign load_o = kick || (mode_we && mode_d.run && !mode_q.run);
  assign mode_o = mode_q;
  assign time_o = time_q;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (idx)
        IDX_MODE: bus_rdata = {26'd0, mode_q.pulse_len, 1'b0, mode_q.irq_en,
                               mode_q.rst_en, mode_q.run};
        IDX_TIME: bus_rdata = {18'd0, time_q.reload, time_q.div_sel};
        IDX_STAT: bus_rdata = {31'd0, status_i};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assert_mode_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && hit && idx == IDX_MODE && bus_wdata[23:12] != MODE_KEY)
      |=> $stable(mode_q));

  assert_time_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && hit && idx == IDX_TIME && bus_wdata[25:14] != TIME_KEY)
      |=> $stable(time_q));
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale
  import kwdt_pkg::*;
#(
  parameter int PRE_BASE = 3,
  parameter int PRE_STEP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = PRE_BASE + PRE_STEP * ((1 << SEL_W) - 1);
  localparam int NSEL  = 1 << SEL_W;

  logic [DIV_W-1:0] lim [NSEL];
  logic [DIV_W-1:0] div_q, div_d;
  logic             div_en;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    localparam int unsigned LIMV = (1 << (PRE_BASE + PRE_STEP * g)) - 1;
    assign lim[g] = LIMV[DIV_W-1:0];
  end

  // >= keeps a mid-count select change from running past the new limit
  assign tick   = run && (div_q >= lim[sel]);
  assign div_en = run || clear || (div_q != '0);

  always_comb begin
    if (clear || !run || tick) div_d = '0;
    else                       div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  assert_tick_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (div_q == '0));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int CNT_LSB = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                rst_en,
  input  logic                irq_en,
  input  logic [1:0]          pulse_len,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                load,
  input  logic                tick,
  output logic                status_o,
  output logic                wdt_rst_o,
  output logic                wdt_irq_o
);
  localparam int CNT_W = RELOAD_W + CNT_LSB;
  localparam logic [PULSE_W-1:0] PULSE_MAX = PULSE_W'(16);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               stat_q, stat_d;
  logic [PULSE_W-1:0] pulse_q, pulse_d;
  logic               fire;

  assign fire = run && !load && !stat_q && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    stat_d = stat_q;
    if (load) begin
      cnt_d  = {reload, {CNT_LSB{1'b0}}};
      stat_d = 1'b0;
    end else if (!run) begin
      stat_d = 1'b0;
    end else begin
      if (tick && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
      if (fire)                stat_d = 1'b1;
    end
  end

  always_comb begin
    pulse_d = pulse_q;
    if (!run && !load)          pulse_d = '0;
    else if (fire && rst_en)    pulse_d = PULSE_W'(2) << pulse_len;
    else if (pulse_q != '0)     pulse_d = pulse_q - PULSE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stat_q  <= 1'b0;
      pulse_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      stat_q  <= stat_d;
      pulse_q <= pulse_d;
    end
  end

  assign status_o  = stat_q;
  assign wdt_rst_o = run && (pulse_q != '0);
  assign wdt_irq_o = run && irq_en && stat_q;

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_flag_from_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> ($past(cnt_q) == '0));

  assert_stopped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> (!stat_q && pulse_q == '0));

  assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= PULSE_MAX);
endmodule

// File: rtl/key_wdt.sv
module key_wdt
  import kwdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CNT_LSB  = 12,
  parameter int PRE_BASE = 3,
  parameter int PRE_STEP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);
  logic [1:0] sync_q;
  logic       rst_sync_n;
  mode_t      mode;
  time_t      tcfg;
  logic       load, tick, status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  kwdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status_i  (status),
    .mode_o    (mode),
    .time_o    (tcfg),
    .load_o    (load),
    .bus_rdata (bus_rdata)
  );

  kwdt_prescale #(.PRE_BASE(PRE_BASE), .PRE_STEP(PRE_STEP)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (mode.run),
    .clear (load),
    .sel   (tcfg.div_sel),
    .tick  (tick)
  );

  kwdt_counter #(.CNT_LSB(CNT_LSB)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (mode.run),
    .rst_en    (mode.rst_en),
    .irq_en    (mode.irq_en),
    .pulse_len (mode.pulse_len),
    .reload    (tcfg.reload),
    .load      (load),
    .tick      (tick),
    .status_o  (status),
    .wdt_rst_o (wdt_rst_o),
    .wdt_irq_o (wdt_irq_o)
  );
endmodule

// File: tb/key_wdt_tb.sv
module key_wdt_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o;
  logic        wdt_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  key_wdt #(.ADDR_W(4), .CNT_LSB(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor: pops expected read data and compares mid-cycle
  always @(negedge clk) begin
    if (bus_valid && !bus_write) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (bus_rdata !== e.data) begin
        errors++;
        $display("FAIL %s: read got %08h expected %08h", e.tag, bus_rdata, e.data);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back('{data: e, tag: tag});
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pin(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: pin got %0b expected %0b", tag, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    wait_cyc(3);
    pin(wdt_rst_o, 1'b0, "R10 rst low in reset");
    pin(wdt_irq_o, 1'b0, "R10 irq low in reset");
    rst_n = 1;
    wait_cyc(4);
    rd(4'h0, 32'h0,    "R10 settings reset");
    rd(4'h4, 32'h3FFF, "R10 timing reset");
    rd(4'hC, 32'h0,    "R10 status reset");
    rd(4'h8, 32'h0,    "R3 restart word reads zero");

    // R1: key on settings word
    wr(4'h0, 32'h00AB_D037);
    rd(4'h0, 32'h0, "R1 bad key ignored");
    wr(4'h0, 32'h00AB_C036);
    rd(4'h0, 32'h36, "R1 good key accepted, R3 key reads zero");

    // R2: key on timing word
    wr(4'h4, 32'h0093_000C);
    rd(4'h4, 32'h3FFF, "R2 bad key ignored");
    wr(4'h4, 32'h0092_000C);
    rd(4'h4, 32'h000C, "R2 good key accepted, R3 fields");

    // Scenario A: reload 3, /8, pulse code 3, irq on -> 3*4*8 = 96 cycles
    wr(4'h0, 32'h00AB_C037);
    wr(4'h8, 32'h0000_1999);
    wait_cyc(96);
    pin(wdt_irq_o, 1'b0, "R5 no irq before expiry");
    pin(wdt_rst_o, 1'b0, "R5 no rst before expiry");
    wait_cyc(1);
    pin(wdt_irq_o, 1'b1, "R7 irq at expiry");
    pin(wdt_rst_o, 1'b1, "R6 rst at expiry");
    wait_cyc(15);
    pin(wdt_rst_o, 1'b1, "R6 rst still high at 16th cycle");
    wait_cyc(1);
    pin(wdt_rst_o, 1'b0, "R6 rst ends after 16 cycles");
    pin(wdt_irq_o, 1'b1, "R7 irq holds");
    rd(4'hC, 32'h1, "R8 flag set");
    wait_cyc(20);
    pin(wdt_irq_o, 1'b1, "R7 irq still holds");

    // R4: near-miss word does nothing, exact word clears and reloads
    wr(4'h8, 32'h0000_1998);
    rd(4'hC, 32'h1, "R4 wrong restart word ignored");
    wr(4'h8, 32'h0000_1999);
    pin(wdt_irq_o, 1'b0, "R7 irq cleared by restart");
    wr(4'h8, 32'h0000_1998);
    wait_cyc(94);
    pin(wdt_irq_o, 1'b0, "R4 timing not shifted (early)");
    wait_cyc(1);
    pin(wdt_irq_o, 1'b1, "R4 expiry at original time");

    // Scenario B: reload 1, /64, pulse code 0, irq off -> 1*4*64 = 256
    wr(4'h4, 32'h0092_0005);
    wr(4'h0, 32'h00AB_C003);
    wr(4'h8, 32'h0000_1999);
    rd(4'hC, 32'h0, "R8 flag cleared by restart");
    wait_cyc(254);
    pin(wdt_rst_o, 1'b0, "R5 /64 no rst before expiry");
    wait_cyc(1);
    pin(wdt_rst_o, 1'b1, "R6 code 0 pulse start");
    pin(wdt_irq_o, 1'b0, "R7 irq disabled stays low");
    wait_cyc(1);
    pin(wdt_rst_o, 1'b1, "R6 code 0 second cycle");
    wait_cyc(1);
    pin(wdt_rst_o, 1'b0, "R6 code 0 ends after 2");
    rd(4'hC, 32'h1, "R8 flag set without irq");

    // Scenario C: stop, hold, restart by run bit
    wr(4'h4, 32'h0092_000C);
    wr(4'h0, 32'h00AB_C005);
    wr(4'h8, 32'h0000_1999);
    wait_cyc(50);
    wr(4'h0, 32'h00AB_C004);
    wait_cyc(200);
    pin(wdt_irq_o, 1'b0, "R9 stopped no irq");
    pin(wdt_rst_o, 1'b0, "R9 stopped no rst");
    rd(4'hC, 32'h0, "R9 stopped no expiry");
    wr(4'h0, 32'h00AB_C005);
    wait_cyc(96);
    pin(wdt_irq_o, 1'b0, "R9 run-bit load (early)");
    wait_cyc(1);
    pin(wdt_irq_o, 1'b1, "R9 run-bit load expiry");
    pin(wdt_rst_o, 1'b0, "R6 rst disabled no pulse");
    wr(4'h0, 32'h00AB_C004);
    pin(wdt_irq_o, 1'b0, "R9 irq drops on stop");
    rd(4'hC, 32'h0, "R8 flag cleared by stop");

    wait_cyc(2);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d reads never observed, expected 0", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule